// File: doc/BRIEF.md
# DDR SDRAM Command Monitor

This block sits beside a DDR SDRAM control bus and classifies, on every rising clock edge, the command the controller is presenting: chip select, row strobe, column strobe, write enable, clock enable, the auto-precharge address bit and the bank address. It reports a decoded command code. It keeps an open or closed flag for each bank and tracks the device power state from clock-enable transitions. It raises a violation flag with a reason code whenever a command breaks a bank-state or timing rule.

Timing rules are enforced with per-bank down-counters. A read or write with auto-precharge loads a lockout window computed from the burst length, the precharge period and the write-recovery period. A global counter tracks the precharge period after an explicit precharge, so a mode register load that comes too early is flagged. All outputs are registered. A command sampled at edge k is reported after edge k and holds until edge k+1.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With `cs_n` high and clock enable high in both cycles, `cmd_code` is 0 (deselect) whatever the strobes are. With `cs_n` low and `ras_n`, `cas_n`, `we_n` all high, it is 1 (no operation). Every output reflects the command sampled at the previous rising edge.
- R2: With `cs_n` low, the strobe triples (`ras_n`,`cas_n`,`we_n`) decode as follows. 011 is activate (4). 101 is read: 5, or 6 when `addr[10]` is high. 100 is write: 7, or 8 when `addr[10]` is high. 110 is burst stop (11). 001 is auto refresh (12). Activate marks bank `ba` open.
- R3: Triple 000 with clock enable high is a mode register load: code 2 when `ba[0]` is 0 and code 3 when `ba[0]` is 1. It is legal only if no bank is open, no bank is in a lockout window and at least tRP cycles have passed since the last precharge. Otherwise `viol` is set with reason 2.
- R4: Triple 010 is a precharge. With `addr[10]` high it is code 10 and closes every bank, whatever `ba` is. With `addr[10]` low it is code 9 and closes only bank `ba`. Both restart the tRP window.
- R5: A read with auto-precharge seen at edge n closes its bank. Any activate, read, write or precharge to that bank before edge n + BL/2 + tRP gets reason 1. A precharge-all while any bank is locked also gets reason 1.
- R6: A write with auto-precharge seen at edge n closes its bank and locks it in the same way until edge n + BL/2 + 1 + tWR + tRP.
- R7: An activate to an open bank gets reason 3. A read or write to a closed bank gets reason 4. An auto refresh while any bank is open gets reason 5. `viol_code` is 0 exactly when `viol` is low.
- R8: A command that raises `viol` changes no bank flag, no counter and no power state.
- R9: Triple 001 with clock enable falling from high to low is self-refresh entry: code 13, `pwr_state` 1.
- R10: A deselect or no operation with clock enable falling is power-down entry (code 14). `pwr_state` becomes 2 if all banks are closed and 3 if any bank is open. Any other command with clock enable falling is code 17 with reason 6, and `pwr_state` stays 0.
- R11: While clock enable is low in both the previous and current cycle, `cmd_code` is 16 and all inputs other than clock enable are ignored. Clock enable rising gives code 15 and `pwr_state` 0.
- R12: Synchronous reset (`rst_n` low) closes all banks, clears all counters, sets `pwr_state` to 0, `cmd_code` to 0 and `viol` to 0.
- R13: Burst length (2, 4 or 8, halved by a right shift), tRP and tWR are captured while reset is held. Later changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures configuration |
| cke | input | 1 | Clock enable of the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address; bit AP_BIT selects auto-precharge or all-bank precharge |
| ba | input | BA_W | Bank address |
| cfg_bl | input | BL_W | Burst length: 2, 4 or 8 |
| cfg_trp | input | TIM_W | Precharge period in cycles |
| cfg_twr | input | TIM_W | Write-recovery period in cycles |
| cmd_code | output | 5 | Decoded command of the previous edge |
| bank_open | output | NUM_BANKS | One bit per bank, high when open |
| pwr_state | output | 2 | 0 run, 1 self refresh, 2 precharge power-down, 3 active power-down |
| viol | output | 1 | Rule violation for the previous command |
| viol_code | output | 3 | Violation reason, 0 when none |

## Verification
Directed sequences place a command one cycle before and exactly at the end of each lockout window, for both read and write auto-precharge. This separates an off-by-one in the BL/2, tWR and tRP sums from a correct window. The same strobe triples are issued with `addr[10]` low and high, and with different bank addresses, to tell single-bank actions from all-bank ones. Power-down is entered with all banks closed and with one open, and junk commands are driven while clock enable stays low, to show which low-power state is chosen and that held cycles are ignored. A long seeded random mix of commands, banks and clock-enable drops is checked against a bench model built from the requirements.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

   typedef enum logic [4:0] {
      CMD_DESEL   = 5'd0,
      CMD_NOP     = 5'd1,
      CMD_MRS     = 5'd2,
      CMD_EMRS    = 5'd3,
      CMD_ACT     = 5'd4,
      CMD_RD      = 5'd5,
      CMD_RDA     = 5'd6,
      CMD_WR      = 5'd7,
      CMD_WRA     = 5'd8,
      CMD_PRE     = 5'd9,
      CMD_PREA    = 5'd10,
      CMD_BST     = 5'd11,
      CMD_AREF    = 5'd12,
      CMD_SREF_IN = 5'd13,
      CMD_PD_IN   = 5'd14,
      CMD_LP_EXIT = 5'd15,
      CMD_LP_HOLD = 5'd16,
      CMD_BAD_CKE = 5'd17
   } cmd_e;

   typedef enum logic [1:0] {
      PWR_RUN  = 2'd0,
      PWR_SREF = 2'd1,
      PWR_PPD  = 2'd2,
      PWR_APD  = 2'd3
   } pwr_e;

   typedef enum logic [2:0] {
      VR_NONE       = 3'd0,
      VR_LOCKED     = 3'd1,
      VR_MRS_BUSY   = 3'd2,
      VR_ACT_OPEN   = 3'd3,
      VR_ACC_CLOSED = 3'd4,
      VR_REF_OPEN   = 3'd5,
      VR_BAD_CKE    = 3'd6
   } vr_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_mon_pkg::*;
(
   input  logic cke_q,
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic ap,
   input  logic ba_lsb,
   output cmd_e cmd
);

   logic [2:0] strobes;
   assign strobes = {ras_n, cas_n, we_n};

   always_comb begin
      cmd = CMD_DESEL;
      if (!cke_q) begin
         // low-power hold or exit: nothing else is decoded
         cmd = cke ? CMD_LP_EXIT : CMD_LP_HOLD;
      end else if (!cke) begin
         if (cs_n || strobes == 3'b111) begin
            cmd = CMD_PD_IN;
         end else if (strobes == 3'b001) begin
            cmd = CMD_SREF_IN;
         end else begin
            cmd = CMD_BAD_CKE;
         end
      end else if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         case (strobes)
            3'b111:  cmd = CMD_NOP;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = ap ? CMD_RDA : CMD_RD;
            3'b100:  cmd = ap ? CMD_WRA : CMD_WR;
            3'b010:  cmd = ap ? CMD_PREA : CMD_PRE;
            3'b110:  cmd = CMD_BST;
            3'b001:  cmd = CMD_AREF;
            default: cmd = ba_lsb ? CMD_EMRS : CMD_MRS;
         endcase
      end
   end

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
   parameter int CNT_W = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_open,
   input  logic             set_closed,
   input  logic             lock_load,
   input  logic [CNT_W-1:0] lock_len,
   output logic             is_open,
   output logic             is_locked
);

   logic [CNT_W-1:0] lock_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open  <= 1'b0;
         lock_cnt <= '0;
      end else begin
         if (set_open) begin
            is_open <= 1'b1;
         end else if (set_closed) begin
            is_open <= 1'b0;
         end
         if (lock_load) begin
            lock_cnt <= lock_len;
         end else if (lock_cnt != '0) begin
            lock_cnt <= lock_cnt - 1'b1;
         end
      end
   end

   assign is_locked = (lock_cnt != '0);

endmodule

// File: rtl/ddr_pwr_track.sv
module ddr_pwr_track
   import ddr_mon_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  cmd_e cmd,
   input  logic any_open,
   output logic cke_q,
   output pwr_e pwr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q <= 1'b1;
         pwr   <= PWR_RUN;
      end else begin
         cke_q <= cke;
         case (cmd)
            CMD_SREF_IN: pwr <= PWR_SREF;
            CMD_PD_IN:   pwr <= any_open ? PWR_APD : PWR_PPD;
            CMD_LP_EXIT: pwr <= PWR_RUN;
            default:     pwr <= pwr;
         endcase
      end
   end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
   import ddr_mon_pkg::*;
#(
   parameter int  NUM_BANKS = 4,
   parameter int  ADDR_W    = 13,
   parameter int  AP_BIT    = 10,
   parameter int  TIM_W     = 4,
   parameter int  BL_W      = 4,
   localparam int BA_W      = $clog2(NUM_BANKS)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [BA_W-1:0]      ba,
   input  logic [BL_W-1:0]      cfg_bl,
   input  logic [TIM_W-1:0]     cfg_trp,
   input  logic [TIM_W-1:0]     cfg_twr,
   output logic [4:0]           cmd_code,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [1:0]           pwr_state,
   output logic                 viol,
   output logic [2:0]           viol_code
);

   localparam int WIDE_W = (TIM_W > BL_W) ? TIM_W : BL_W;
   localparam int CNT_W  = WIDE_W + 2;

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_chk_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (AP_BIT >= ADDR_W) begin : g_chk_ap
      $error("AP_BIT must lie inside the address");
   end
   if (BL_W < 4 || TIM_W < 1) begin : g_chk_widths
      $error("BL_W must hold 8 and TIM_W must be positive");
   end

   // configuration captured while reset is held
   logic [BL_W-2:0]  bl_half_q;
   logic [TIM_W-1:0] trp_q;
   logic [TIM_W-1:0] twr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bl_half_q <= cfg_bl[BL_W-1:1];
         trp_q     <= cfg_trp;
         twr_q     <= cfg_twr;
      end
   end

   logic unused_inputs;
   assign unused_inputs = ^{addr, cfg_bl[0]};

   logic cke_q;
   cmd_e cmd;
   pwr_e pwr;

   ddr_cmd_decode u_decode (
      .cke_q  (cke_q),
      .cke    (cke),
      .cs_n   (cs_n),
      .ras_n  (ras_n),
      .cas_n  (cas_n),
      .we_n   (we_n),
      .ap     (addr[AP_BIT]),
      .ba_lsb (ba[0]),
      .cmd    (cmd)
   );

   logic [NUM_BANKS-1:0] open_v;
   logic [NUM_BANKS-1:0] lock_v;
   logic                 tgt_open;
   logic                 tgt_lock;
   logic [CNT_W-1:0]     pre_cnt;
   vr_e                  reason;
   logic                 ok;

   assign tgt_open = open_v[ba];
   assign tgt_lock = lock_v[ba];

   always_comb begin
      reason = VR_NONE;
      case (cmd)
         CMD_ACT: begin
            if (tgt_lock)      reason = VR_LOCKED;
            else if (tgt_open) reason = VR_ACT_OPEN;
         end
         CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
            if (tgt_lock)       reason = VR_LOCKED;
            else if (!tgt_open) reason = VR_ACC_CLOSED;
         end
         CMD_PRE: begin
            if (tgt_lock) reason = VR_LOCKED;
         end
         CMD_PREA: begin
            if (|lock_v) reason = VR_LOCKED;
         end
         CMD_MRS, CMD_EMRS: begin
            if ((|open_v) || (|lock_v) || (pre_cnt != '0)) reason = VR_MRS_BUSY;
         end
         CMD_AREF: begin
            if (|open_v) reason = VR_REF_OPEN;
         end
         CMD_BAD_CKE: reason = VR_BAD_CKE;
         default:     reason = VR_NONE;
      endcase
   end

   assign ok = (reason == VR_NONE);

   // window lengths, one less than the distance to the first legal edge
   logic [CNT_W-1:0] rda_len;
   logic [CNT_W-1:0] wra_len;
   logic [CNT_W-1:0] pre_len;
   logic [CNT_W-1:0] lock_len;

   assign rda_len  = CNT_W'(bl_half_q) + CNT_W'(trp_q) - CNT_W'(1);
   assign wra_len  = CNT_W'(bl_half_q) + CNT_W'(twr_q) + CNT_W'(trp_q);
   assign pre_len  = (trp_q == '0) ? '0 : CNT_W'(trp_q) - CNT_W'(1);
   assign lock_len = (cmd == CMD_WRA) ? wra_len : rda_len;

   logic is_auto;
   logic is_close_one;
   logic is_prech;
   assign is_auto      = (cmd == CMD_RDA) || (cmd == CMD_WRA);
   assign is_close_one = is_auto || (cmd == CMD_PRE);
   assign is_prech     = (cmd == CMD_PRE) || (cmd == CMD_PREA);

   for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
      logic hit;
      logic do_open;
      logic do_close;
      logic do_lock;

      assign hit      = (ba == BA_W'(gi));
      assign do_open  = ok && hit && (cmd == CMD_ACT);
      assign do_close = ok && ((hit && is_close_one) || (cmd == CMD_PREA));
      assign do_lock  = ok && hit && is_auto;

      ddr_bank_slot #(.CNT_W(CNT_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_open   (do_open),
         .set_closed (do_close),
         .lock_load  (do_lock),
         .lock_len   (lock_len),
         .is_open    (open_v[gi]),
         .is_locked  (lock_v[gi])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_cnt <= '0;
      end else if (ok && is_prech) begin
         pre_cnt <= pre_len;
      end else if (pre_cnt != '0) begin
         pre_cnt <= pre_cnt - 1'b1;
      end
   end

   ddr_pwr_track u_pwr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .cmd      (cmd),
      .any_open (|open_v),
      .cke_q    (cke_q),
      .pwr      (pwr)
   );

   logic [4:0] cmd_q;
   logic       viol_q;
   logic [2:0] reason_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= CMD_DESEL;
         viol_q   <= 1'b0;
         reason_q <= VR_NONE;
      end else begin
         cmd_q    <= cmd;
         viol_q   <= !ok;
         reason_q <= reason;
      end
   end

   assign cmd_code  = cmd_q;
   assign bank_open = open_v;
   assign pwr_state = pwr;
   assign viol      = viol_q;
   assign viol_code = reason_q;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
   import ddr_mon_pkg::*;
#(
   parameter int NB = 4
)(
   input logic          clk,
   input logic          rst_n,
   input logic          cke,
   input logic          cke_q,
   input logic [4:0]    cmd_code,
   input logic [NB-1:0] bank_open,
   input logic [1:0]    pwr_state,
   input logic          viol,
   input logic [2:0]    viol_code
);

   AST_VIOL_HAS_REASON: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> viol_code != 3'd0); // R7

   AST_QUIET_NO_REASON: assert property (@(posedge clk) disable iff (!rst_n)
      !viol |-> viol_code == 3'd0); // R7

   AST_VIOL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> bank_open == $past(bank_open)); // R8

   AST_LOWPOWER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_q && !cke) |=> (bank_open == $past(bank_open) && pwr_state == $past(pwr_state))); // R11

   AST_MRS_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_code == CMD_MRS || cmd_code == CMD_EMRS) && !viol) |-> bank_open == '0); // R3

   AST_PREA_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_PREA && !viol) |-> bank_open == '0); // R4

   AST_PPD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PWR_PPD) |-> bank_open == '0); // R10

   AST_SREF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_SREF_IN) |-> pwr_state == PWR_SREF); // R9

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.NB(NUM_BANKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cke_q     (cke_q),
   .cmd_code  (cmd_code),
   .bank_open (bank_open),
   .pwr_state (pwr_state),
   .viol      (viol),
   .viol_code (viol_code)
);

// File: tb/sim_ddr_cmd_monitor.sv
module sim_ddr_cmd_monitor;

   localparam bit [2:0] S_NOP = 3'b111;
   localparam bit [2:0] S_ACT = 3'b011;
   localparam bit [2:0] S_RD  = 3'b101;
   localparam bit [2:0] S_WR  = 3'b100;
   localparam bit [2:0] S_PRE = 3'b010;
   localparam bit [2:0] S_BST = 3'b110;
   localparam bit [2:0] S_REF = 3'b001;
   localparam bit [2:0] S_MRS = 3'b000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1;
   logic        ras_n = 1'b1;
   logic        cas_n = 1'b1;
   logic        we_n = 1'b1;
   logic [12:0] addr = '0;
   logic [1:0]  ba = '0;
   logic [3:0]  cfg_bl = 4'd4;
   logic [3:0]  cfg_trp = 4'd3;
   logic [3:0]  cfg_twr = 4'd2;
   logic [4:0]  cmd_code;
   logic [3:0]  bank_open;
   logic [1:0]  pwr_state;
   logic        viol;
   logic [2:0]  viol_code;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   // bench model
   bit m_open[4];
   int m_lock[4];
   int m_pre;
   int m_pwr;
   bit m_ckeq;
   int m_half, m_trp, m_twr;

   always #10 clk = ~clk;

   ddr_cmd_monitor u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .cfg_bl(cfg_bl),
      .cfg_trp(cfg_trp), .cfg_twr(cfg_twr), .cmd_code(cmd_code),
      .bank_open(bank_open), .pwr_state(pwr_state), .viol(viol),
      .viol_code(viol_code)
   );

   function automatic int exp_code(bit k, bit cs, bit [2:0] s, bit ap, bit [1:0] b);
      if (!m_ckeq) return k ? 15 : 16;                 // R11
      if (!k) begin
         if (cs || s == S_NOP) return 14;              // R10
         if (s == S_REF) return 13;                    // R9
         return 17;
      end
      if (cs) return 0;                                // R1
      case (s)
         S_NOP:   return 1;
         S_ACT:   return 4;
         S_RD:    return ap ? 6 : 5;
         S_WR:    return ap ? 8 : 7;
         S_PRE:   return ap ? 10 : 9;
         S_BST:   return 11;
         S_REF:   return 12;
         default: return b[0] ? 3 : 2;                 // R3
      endcase
   endfunction

   function automatic int exp_reason(int c, bit [1:0] b);
      bit anyo = 0;
      bit anyl = 0;
      for (int i = 0; i < 4; i++) begin
         if (m_open[i]) anyo = 1;
         if (m_lock[i] > 0) anyl = 1;
      end
      case (c)
         4:          return (m_lock[b] > 0) ? 1 : (m_open[b] ? 3 : 0);
         5, 6, 7, 8: return (m_lock[b] > 0) ? 1 : (!m_open[b] ? 4 : 0);
         9:          return (m_lock[b] > 0) ? 1 : 0;
         10:         return anyl ? 1 : 0;
         2, 3:       return (anyo || anyl || m_pre > 0) ? 2 : 0;
         12:         return anyo ? 5 : 0;
         17:         return 6;
         default:    return 0;
      endcase
   endfunction

   task automatic model_update(int c, int r, bit [1:0] b, bit k);
      bit anyo = 0;
      for (int i = 0; i < 4; i++) begin
         if (m_open[i]) anyo = 1;
         if (m_lock[i] > 0) m_lock[i]--;
      end
      if (m_pre > 0) m_pre--;
      if (r == 0) begin
         case (c)
            4: m_open[b] = 1;
            6: begin m_open[b] = 0; m_lock[b] = m_half + m_trp - 1; end
            8: begin m_open[b] = 0; m_lock[b] = m_half + m_twr + m_trp; end
            9: begin m_open[b] = 0; m_pre = (m_trp > 0) ? m_trp - 1 : 0; end
            10: begin
               for (int i = 0; i < 4; i++) m_open[i] = 0;
               m_pre = (m_trp > 0) ? m_trp - 1 : 0;
            end
            13: m_pwr = 1;
            14: m_pwr = anyo ? 3 : 2;
            15: m_pwr = 0;
            default: ;
         endcase
      end
      m_ckeq = k;
   endtask

   task automatic compare(int ec, int er, string tag);
      logic [3:0] eo;
      for (int i = 0; i < 4; i++) eo[i] = m_open[i];
      checks++;
      if (int'(cmd_code) != ec || bank_open != eo || int'(pwr_state) != m_pwr ||
          viol != (er != 0) || int'(viol_code) != er) begin
         fails++;
         $display("FAIL %s: code=%0d exp %0d, banks=%b exp %b, pwr=%0d exp %0d, viol=%0d exp %0d, reason=%0d exp %0d",
                  tag, cmd_code, ec, bank_open, eo, pwr_state, m_pwr, viol, (er != 0), viol_code, er);
      end
   endtask

   task automatic step(bit k, bit cs, bit [2:0] s, bit ap, bit [1:0] b, string tag);
      int ec;
      int er;
      ec = exp_code(k, cs, s, ap, b);
      er = exp_reason(ec, b);
      cke = k;
      cs_n = cs;
      {ras_n, cas_n, we_n} = s;
      addr = 13'($urandom);
      addr[10] = ap;
      ba = b;
      @(posedge clk);
      @(negedge clk);
      model_update(ec, er, b, k);
      compare(ec, er, tag);
   endtask

   task automatic apply_reset(int bl, int trp, int twr);
      rst_n = 1'b0;
      cke = 1'b1;
      cs_n = 1'b1;
      cfg_bl = 4'(bl);
      cfg_trp = 4'(trp);
      cfg_twr = 4'(twr);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_lock[i] = 0; end
      m_pre = 0; m_pwr = 0; m_ckeq = 1;
      m_half = bl >> 1; m_trp = trp; m_twr = twr;
      compare(0, 0, "R12 reset state");
      // R13: later configuration changes must not matter
      cfg_bl = 4'd8;
      cfg_trp = 4'd15;
      cfg_twr = 4'd15;
   endtask

   task automatic nops(int n, string tag);
      for (int i = 0; i < n; i++) step(1, 0, S_NOP, 0, 2'(i), tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240917));
      apply_reset(4, 3, 2);

      step(1, 1, S_ACT, 1, 2'd1, "R1 deselect ignores strobes");
      step(1, 0, S_NOP, 0, 2'd0, "R1 no operation");
      step(1, 0, S_MRS, 0, 2'd0, "R3 normal mode load idle");
      step(1, 0, S_MRS, 0, 2'd1, "R3 extended mode load idle");
      step(1, 0, S_ACT, 0, 2'd0, "R2 activate bank0");
      step(1, 0, S_ACT, 0, 2'd0, "R7 R8 activate open bank");
      step(1, 0, S_RD,  0, 2'd2, "R7 read closed bank");
      step(1, 0, S_WR,  0, 2'd3, "R7 write closed bank");
      step(1, 0, S_REF, 0, 2'd1, "R7 refresh with bank open");
      step(1, 0, S_MRS, 0, 2'd0, "R3 mode load with bank open");
      step(1, 0, S_RD,  0, 2'd0, "R2 read");
      step(1, 0, S_WR,  0, 2'd0, "R2 write");
      step(1, 0, S_BST, 0, 2'd0, "R2 burst stop");

      // R5: BL/2 + tRP = 2 + 3 = 5
      step(1, 0, S_RD, 1, 2'd0, "R5 read auto-precharge");
      nops(3, "R5 window");
      step(1, 0, S_ACT, 0, 2'd0, "R5 R13 activate one cycle early");
      step(1, 0, S_ACT, 0, 2'd0, "R5 activate at window end");

      // R6: BL/2 + 1 + tWR + tRP = 2 + 1 + 2 + 3 = 8
      step(1, 0, S_WR, 1, 2'd0, "R6 write auto-precharge");
      nops(6, "R6 window");
      step(1, 0, S_RD, 0, 2'd0, "R6 read one cycle early");
      step(1, 0, S_ACT, 0, 2'd0, "R6 activate at window end");

      step(1, 0, S_ACT, 0, 2'd1, "R2 activate bank1");
      step(1, 0, S_ACT, 0, 2'd2, "R2 activate bank2");
      step(1, 0, S_PRE, 0, 2'd1, "R4 single bank precharge");
      step(1, 0, S_PRE, 1, 2'd3, "R4 all bank precharge ignores ba");
      step(1, 0, S_MRS, 0, 2'd0, "R3 mode load inside tRP");
      step(1, 0, S_NOP, 0, 2'd0, "R3 wait");
      step(1, 0, S_MRS, 0, 2'd1, "R3 mode load after tRP");

      step(0, 0, S_NOP, 0, 2'd0, "R10 precharge power-down");
      step(0, 0, S_ACT, 0, 2'd1, "R11 hold ignores activate");
      step(0, 0, S_PRE, 1, 2'd0, "R11 hold ignores precharge");
      step(1, 0, S_NOP, 0, 2'd0, "R11 exit");
      step(1, 0, S_ACT, 0, 2'd3, "R2 activate bank3");
      step(0, 1, S_MRS, 0, 2'd0, "R10 active power-down");
      step(0, 0, S_RD, 0, 2'd3, "R11 hold ignores read");
      step(1, 1, S_NOP, 0, 2'd0, "R11 exit");
      step(1, 0, S_PRE, 0, 2'd3, "R4 close bank3");
      step(1, 0, S_REF, 0, 2'd0, "R2 auto refresh idle");
      step(0, 0, S_REF, 0, 2'd0, "R9 self refresh entry");
      step(0, 0, S_ACT, 0, 2'd2, "R11 hold in self refresh");
      step(1, 0, S_NOP, 0, 2'd0, "R11 exit self refresh");
      step(0, 0, S_ACT, 0, 2'd0, "R10 illegal clock-enable drop");
      step(0, 0, S_NOP, 0, 2'd0, "R11 hold after illegal drop");
      step(1, 0, S_NOP, 0, 2'd0, "R11 exit after illegal drop");

      for (int n = 0; n < 4000; n++) begin
         bit k;
         if (!m_ckeq) k = ($urandom_range(0, 1) == 1);
         else k = ($urandom_range(0, 15) != 0);
         step(k, ($urandom_range(0, 7) == 0), 3'($urandom_range(0, 7)),
              1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), "R2 R5 R6 R7 random");
      end

      // second configuration: BL/2 + tRP = 4 + 1 = 5
      apply_reset(8, 1, 0);
      step(1, 0, S_ACT, 0, 2'd2, "R2 activate after reset");
      step(1, 0, S_RD, 1, 2'd2, "R5 read auto-precharge BL8");
      nops(3, "R5 window BL8");
      step(1, 0, S_ACT, 0, 2'd2, "R5 R13 activate one cycle early BL8");
      step(1, 0, S_ACT, 0, 2'd2, "R5 activate at window end BL8");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule